// File: doc/BRIEF.md
# Ethernet Receive Descriptor Status Writer

This block follows one received Ethernet frame, delivered one byte per beat with an end-of-frame marker on the final byte. It splits the stored bytes into fixed-size receive buffers. Each time a buffer is closed, it emits a single descriptor write made of a length, a last-buffer flag and an 8-bit status word. A buffer closes either because it is full or because the frame has ended.

The descriptor that closes the final buffer carries the frame's status:

- broadcast and multicast classification of the destination address, which is taken from the first six bytes;
- the promiscuous-mode miss indication;
- length violation against a programmable maximum;
- truncation beyond 2032 bytes;
- the non-octet and CRC error indications, derived from the residual bit count and the external CRC result;
- FIFO overrun.

Overrun clears the flags it makes meaningless. A non-octet frame never reports a CRC error. The surrounding MAC computes the CRC, and it also handles DMA and the descriptor ring.

Top module: `rx_desc_status_writer`

## Requirements
- R1: While reset is low, and in the first cycle after it, `desc_wr` is low.
- R2: When a stored byte fills a buffer of `BUF_BYTES` bytes and is not the end-of-frame byte, exactly one descriptor is written in the cycle after that byte. It has `desc_last`=0, `desc_len`=`BUF_BYTES` and `desc_status`=0.
- R3: The end-of-frame byte causes exactly one descriptor write in the next cycle. It has `desc_last`=1, and `desc_len` is the total byte count of the frame including the CRC. A frame whose length is an exact multiple of `BUF_BYTES` produces no extra non-last descriptor for its final buffer.
- R4: Status bit 5 (broadcast) is set when all six destination bytes are 0xFF. Status bit 4 (multicast) is set when bit 0 of the first byte is 1 and the frame is not broadcast. A frame shorter than six bytes is never broadcast.
- R5: Status bit 3 (miss) is set when `promisc_en`=1 and `rx_addr_hit`=0 on the end-of-frame beat. It is clear when the address recognition hit or promiscuous mode is off.
- R6: Status bit 2 (length violation) is set when the frame length exceeds `max_frame_len`.
- R7: Bytes after byte 2032 are dropped. Such a frame sets status bit 7 (truncated), its last `desc_len` is 2032, and no buffer closes for dropped bytes.
- R8: Status bit 1 (non-octet) is set when `rx_resid_bits`≠0 and `rx_crc_ok`=0. In that case status bit 0 stays clear.
- R9: Status bit 0 (CRC error) is set only when `rx_resid_bits`=0 and `rx_crc_ok`=0.
- R10: Status bit 6 (overrun) is set if `rx_fifo_ovr` was high on any beat of the frame. When it is set, bits 3, 2, 1 and 0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| promisc_en | input | 1 | Promiscuous mode enabled |
| max_frame_len | input | LEN_W | Maximum legal frame length in bytes |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | Marks the final byte of the frame |
| rx_resid_bits | input | 3 | Extra bits after the last whole byte (valid with rx_eof) |
| rx_crc_ok | input | 1 | CRC check passed (valid with rx_eof) |
| rx_fifo_ovr | input | 1 | Receive FIFO overrun on this beat |
| rx_addr_hit | input | 1 | Address recognition hit (valid with rx_eof) |
| desc_wr | output | 1 | One-cycle descriptor write strobe |
| desc_len | output | LEN_W | Descriptor length field |
| desc_last | output | 1 | Descriptor closes the last buffer of the frame |
| desc_status | output | 8 | Status flags, bit positions as in R4 to R10 |

## Verification
Every descriptor is registered once, so it appears exactly one clock after the byte that closed its buffer. This holds for the buffer-filling byte and for the end-of-frame byte alike.

The bench drives bytes on the falling edge and records every write strobe on the following falling edges. Each recorded descriptor therefore belongs to the byte driven one period earlier. Each scenario waits two idle cycles after its frame before comparing the whole list with descriptors predicted from the requirements. Status is compared only on the last descriptor, and the all-zero status is checked on the intermediate ones.

// File: rtl/rxd_pkg.sv
// Shared types for the receive descriptor status writer.
// Assumes an 8-bit status word whose bit order is fixed by the descriptor format.
package rxd_pkg;
    typedef struct packed {
        logic truncated;   // bit 7
        logic overrun;     // bit 6
        logic broadcast;   // bit 5
        logic multicast;   // bit 4
        logic miss;        // bit 3
        logic len_viol;    // bit 2
        logic non_octet;   // bit 1
        logic crc_err;     // bit 0
    } rx_stat_t;
endpackage

// File: rtl/rxd_addr_class.sv
// Destination address classifier.
// Watches the first six bytes of a frame and reports, on the current beat,
// whether the frame is broadcast or multicast.
// Assumes the frame ends with a beat carrying eof, after which state restarts.
module rxd_addr_class (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat,
    input  logic       eof,
    input  logic [7:0] byte_in,
    output logic       is_bcast,
    output logic       is_mcast
);
    localparam int DA_BYTES = 6;

    logic [2:0] idx_q;
    logic       allff_q;
    logic       grp_q;
    logic       in_da;
    logic       allff_nxt;
    logic       grp_nxt;
    logic       da_done;

    // Combine the stored state with the byte on this beat.
    always_comb begin
        in_da     = (idx_q < 3'(DA_BYTES));
        allff_nxt = allff_q & (!in_da | (byte_in == 8'hFF));
        grp_nxt   = (idx_q == 3'd0) ? byte_in[0] : grp_q;
        da_done   = (idx_q >= 3'(DA_BYTES - 1));
        is_bcast  = allff_nxt & da_done;
        is_mcast  = grp_nxt & !is_bcast;
    end

    // Track position inside the destination field and the running flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            allff_q <= 1'b1;
            grp_q   <= 1'b0;
        end else if (beat) begin
            if (eof) begin
                idx_q   <= '0;
                allff_q <= 1'b1;
                grp_q   <= 1'b0;
            end else begin
                if (in_da) idx_q <= idx_q + 3'd1;
                allff_q <= allff_nxt;
                grp_q   <= grp_nxt;
            end
        end
    end
endmodule

// File: rtl/rxd_buf_split.sv
// Buffer splitter.
// Counts frame bytes, keeps only the first TRUNC_LIMIT of them, and flags
// the beat on which a kept byte fills a buffer of BUF_BYTES.
// Assumes LEN_W is wide enough for TRUNC_LIMIT; the total count saturates.
module rxd_buf_split #(
    parameter int BUF_BYTES   = 64,
    parameter int TRUNC_LIMIT = 2032,
    parameter int LEN_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             eof,
    output logic             close_mid,
    output logic [LEN_W-1:0] total_nxt,
    output logic [LEN_W-1:0] last_len
);
    localparam int               BUF_W   = $clog2(BUF_BYTES + 1);
    localparam logic [BUF_W-1:0] BUF_L   = BUF_W'(BUF_BYTES);
    localparam logic [LEN_W-1:0] TRUNC_L = LEN_W'(TRUNC_LIMIT);

    logic [BUF_W-1:0] fill_q;
    logic [LEN_W-1:0] total_q;
    logic [BUF_W-1:0] fill_inc;
    logic             keep;

    // Next counts and the buffer-full condition for this beat.
    always_comb begin
        keep      = (total_q < TRUNC_L);
        fill_inc  = fill_q + BUF_W'(1);
        total_nxt = (&total_q) ? total_q : total_q + LEN_W'(1);
        close_mid = beat & keep & !eof & (fill_inc == BUF_L);
        last_len  = (total_nxt > TRUNC_L) ? TRUNC_L : total_nxt;
    end

    // Advance buffer fill and frame totals; restart on end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q  <= '0;
            total_q <= '0;
        end else if (beat) begin
            if (eof) begin
                fill_q  <= '0;
                total_q <= '0;
            end else begin
                total_q <= total_nxt;
                if (keep) fill_q <= close_mid ? '0 : fill_inc;
            end
        end
    end
endmodule

// File: rtl/rxd_status_merge.sv
// Status merge.
// Forms the final status word from the raw indications with the fixed
// precedence: overrun clears miss, length, non-octet and CRC flags, and a
// non-octet frame never reports a CRC error. Purely combinational.
module rxd_status_merge #(
    parameter int TRUNC_LIMIT = 2032,
    parameter int LEN_W       = 16
) (
    input  logic             bcast,
    input  logic             mcast,
    input  logic             promisc,
    input  logic             addr_hit,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [LEN_W-1:0] max_len,
    input  logic [2:0]       resid,
    input  logic             crc_ok,
    input  logic             ovr,
    output rxd_pkg::rx_stat_t stat
);
    localparam logic [LEN_W-1:0] TRUNC_L = LEN_W'(TRUNC_LIMIT);

    logic odd_bits;

    // Apply the flag precedence to the raw indications.
    always_comb begin
        odd_bits       = (resid != 3'd0);
        stat.truncated = (frame_len > TRUNC_L);
        stat.overrun   = ovr;
        stat.broadcast = bcast;
        stat.multicast = mcast;
        stat.miss      = !ovr & promisc & !addr_hit;
        stat.len_viol  = !ovr & (frame_len > max_len);
        stat.non_octet = !ovr & odd_bits & !crc_ok;
        stat.crc_err   = !ovr & !odd_bits & !crc_ok;
    end
endmodule

// File: rtl/rx_desc_status_writer.sv
// Receive descriptor status writer (top).
// Splits one received frame into fixed-size buffers and writes one descriptor
// per closed buffer, one cycle after the closing byte. Only the last
// descriptor carries length of the whole frame and status.
// Assumes one byte per rx_valid beat and that rx_eof marks the final byte.
module rx_desc_status_writer #(
    parameter int BUF_BYTES   = 64,
    parameter int TRUNC_LIMIT = 2032,
    parameter int LEN_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             promisc_en,
    input  logic [LEN_W-1:0] max_frame_len,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_eof,
    input  logic [2:0]       rx_resid_bits,
    input  logic             rx_crc_ok,
    input  logic             rx_fifo_ovr,
    input  logic             rx_addr_hit,
    output logic             desc_wr,
    output logic [LEN_W-1:0] desc_len,
    output logic             desc_last,
    output logic [7:0]       desc_status
);
    import rxd_pkg::*;

    localparam logic [LEN_W-1:0] BUF_LEN = LEN_W'(BUF_BYTES);

    logic             beat_eof;
    logic             is_bcast;
    logic             is_mcast;
    logic             close_mid;
    logic [LEN_W-1:0] total_nxt;
    logic [LEN_W-1:0] last_len;
    logic             ovr_q;
    logic             ovr_nxt;
    rx_stat_t         stat;

    // End-of-frame beat and sticky overrun including this beat.
    always_comb begin
        beat_eof = rx_valid & rx_eof;
        ovr_nxt  = ovr_q | (rx_valid & rx_fifo_ovr);
    end

    rxd_addr_class u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (rx_valid),
        .eof      (rx_eof),
        .byte_in  (rx_data),
        .is_bcast (is_bcast),
        .is_mcast (is_mcast)
    );

    rxd_buf_split #(
        .BUF_BYTES   (BUF_BYTES),
        .TRUNC_LIMIT (TRUNC_LIMIT),
        .LEN_W       (LEN_W)
    ) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (rx_valid),
        .eof       (rx_eof),
        .close_mid (close_mid),
        .total_nxt (total_nxt),
        .last_len  (last_len)
    );

    rxd_status_merge #(
        .TRUNC_LIMIT (TRUNC_LIMIT),
        .LEN_W       (LEN_W)
    ) u_merge (
        .bcast     (is_bcast),
        .mcast     (is_mcast),
        .promisc   (promisc_en),
        .addr_hit  (rx_addr_hit),
        .frame_len (total_nxt),
        .max_len   (max_frame_len),
        .resid     (rx_resid_bits),
        .crc_ok    (rx_crc_ok),
        .ovr       (ovr_nxt),
        .stat      (stat)
    );

    // Remember an overrun seen anywhere in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovr_q <= 1'b0;
        else if (beat_eof) ovr_q <= 1'b0;
        else               ovr_q <= ovr_nxt;
    end

    // Register the descriptor once per closed buffer; fields hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_wr     <= 1'b0;
            desc_len    <= '0;
            desc_last   <= 1'b0;
            desc_status <= '0;
        end else begin
            desc_wr <= beat_eof | close_mid;
            if (beat_eof) begin
                desc_len    <= last_len;
                desc_last   <= 1'b1;
                desc_status <= stat;
            end else if (close_mid) begin
                desc_len    <= BUF_LEN;
                desc_last   <= 1'b0;
                desc_status <= '0;
            end
        end
    end
endmodule

// File: rtl/rxd_checker.sv
// Assertion checker for rx_desc_status_writer, attached with bind.
// Observes ports only.
module rxd_checker #(
    parameter int BUF_BYTES   = 64,
    parameter int TRUNC_LIMIT = 2032,
    parameter int LEN_W       = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             promisc_en,
    input logic             rx_valid,
    input logic             rx_eof,
    input logic             desc_wr,
    input logic [LEN_W-1:0] desc_len,
    input logic             desc_last,
    input logic [7:0]       desc_status
);
    // Reset holds the write strobe low.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !desc_wr);

    // Intermediate descriptors carry the buffer size and no status.
    assert_mid_desc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr && !desc_last) |-> (desc_len == LEN_W'(BUF_BYTES) && desc_status == 8'h00));

    // A write only follows a received byte.
    assert_write_after_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr |-> $past(rx_valid));

    // A last descriptor follows the end-of-frame byte.
    assert_last_after_eof_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr && desc_last) |-> $past(rx_eof));

    // Broadcast and multicast are exclusive.
    assert_bc_mc_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr |-> !(desc_status[5] && desc_status[4]));

    // Miss only under promiscuous mode.
    assert_miss_promisc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr && desc_status[3]) |-> $past(promisc_en));

    // Length field never exceeds the stored limit; truncation matches it.
    assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr && desc_last) |-> (desc_len <= LEN_W'(TRUNC_LIMIT)));
    assert_trunc_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr && desc_status[7]) |-> (desc_len == LEN_W'(TRUNC_LIMIT)));

    // Non-octet excludes CRC error.
    assert_nonoct_crc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr && desc_status[1]) |-> !desc_status[0]);

    // Overrun clears miss, length, non-octet and CRC flags.
    assert_ovr_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr && desc_status[6]) |-> (desc_status[3:0] == 4'h0));
endmodule

bind rx_desc_status_writer rxd_checker #(
    .BUF_BYTES   (BUF_BYTES),
    .TRUNC_LIMIT (TRUNC_LIMIT),
    .LEN_W       (LEN_W)
) u_rxd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .promisc_en  (promisc_en),
    .rx_valid    (rx_valid),
    .rx_eof      (rx_eof),
    .desc_wr     (desc_wr),
    .desc_len    (desc_len),
    .desc_last   (desc_last),
    .desc_status (desc_status)
);

// File: tb/tb_rx_desc_status_writer.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own descriptors.
module tb_rx_desc_status_writer;
    localparam int BUF   = 64;
    localparam int TRUNC = 2032;
    localparam int LW    = 16;
    localparam int MAXD  = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          promisc_en = 1'b0;
    logic [LW-1:0] max_frame_len = LW'(1518);
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_eof = 1'b0;
    logic [2:0]    rx_resid_bits = '0;
    logic          rx_crc_ok = 1'b1;
    logic          rx_fifo_ovr = 1'b0;
    logic          rx_addr_hit = 1'b1;
    logic          desc_wr;
    logic [LW-1:0] desc_len;
    logic          desc_last;
    logic [7:0]    desc_status;

    int checks = 0;
    int errors = 0;
    int cap_n  = 0;
    int cap_len  [MAXD];
    int cap_last [MAXD];
    int cap_stat [MAXD];

    always #2.5 clk = ~clk;

    rx_desc_status_writer #(.BUF_BYTES(BUF), .TRUNC_LIMIT(TRUNC), .LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .promisc_en(promisc_en), .max_frame_len(max_frame_len),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof),
        .rx_resid_bits(rx_resid_bits), .rx_crc_ok(rx_crc_ok), .rx_fifo_ovr(rx_fifo_ovr),
        .rx_addr_hit(rx_addr_hit), .desc_wr(desc_wr), .desc_len(desc_len),
        .desc_last(desc_last), .desc_status(desc_status)
    );

    // Record every descriptor write, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && desc_wr) begin
            if (cap_n < MAXD) begin
                cap_len[cap_n]  = int'(desc_len);
                cap_last[cap_n] = int'(desc_last);
                cap_stat[cap_n] = int'(desc_status);
            end
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Send one frame and compare all its descriptors with the predicted ones.
    task automatic run_frame(input string req, input int n, input bit da_ff, input bit da_grp,
                             input bit prom, input bit hit, input int resid, input bit crcok,
                             input int ovr_at, input int maxlen);
        int stored, n_mid, exp_stat;
        bit eb, em, tr, ov, ce, no, lv, ms;
        @(negedge clk);
        cap_n = 0;
        promisc_en = prom;
        max_frame_len = LW'(maxlen);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            if (i < 6) rx_data = da_ff ? 8'hFF : ((i == 0) ? {7'h01, da_grp} : 8'h5E);
            else       rx_data = 8'(i);
            rx_eof        = (i == n - 1);
            rx_fifo_ovr   = (i == ovr_at);
            rx_resid_bits = 3'(resid);
            rx_crc_ok     = crcok;
            rx_addr_hit   = hit;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0; rx_fifo_ovr = 1'b0;
        repeat (2) @(negedge clk);
        // Expected descriptors from the requirements.
        stored = (n > TRUNC) ? TRUNC : n;
        n_mid  = stored / BUF - (((n == stored) && (n % BUF == 0)) ? 1 : 0);
        eb = da_ff && (n >= 6);
        em = (da_ff || da_grp) && !eb;
        tr = (n > TRUNC);
        ov = (ovr_at >= 0) && (ovr_at < n);
        ce = !ov && (resid == 0) && !crcok;
        no = !ov && (resid != 0) && !crcok;
        lv = !ov && (n > maxlen);
        ms = !ov && prom && !hit;
        exp_stat = {24'd0, tr, ov, eb, em, ms, lv, no, ce};
        chk({req, " descriptor count"}, cap_n, n_mid + 1);
        for (int k = 0; k < n_mid && k < MAXD; k++) begin
            chk({"R2 ", req, " mid len"}, cap_len[k], BUF);
            chk({"R2 ", req, " mid last"}, cap_last[k], 0);
            chk({"R2 ", req, " mid status"}, cap_stat[k], 0);
        end
        if (n_mid < MAXD) begin
            chk({"R3 ", req, " last flag"}, cap_last[n_mid], 1);
            chk({"R3 ", req, " last len"}, cap_len[n_mid], stored);
            chk({req, " status"}, cap_stat[n_mid], exp_stat);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 desc_wr in reset", int'(desc_wr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 desc_wr after reset", int'(desc_wr), 0);
        chk("R1 no writes captured", cap_n, 0);
    endtask

    task automatic t_unicast();   run_frame("R3 short unicast", 20, 0, 0, 0, 1, 0, 1, -1, 1518); endtask
    task automatic t_bcast();     run_frame("R4 broadcast split", 150, 1, 0, 0, 1, 0, 1, -1, 1518); endtask
    task automatic t_mcast_exact(); run_frame("R4 R3 multicast exact multiple", 128, 0, 1, 0, 1, 0, 1, -1, 1518); endtask
    task automatic t_short_ff();  run_frame("R4 short all-ones frame", 4, 1, 0, 0, 1, 0, 1, -1, 1518); endtask
    task automatic t_miss();
        run_frame("R5 promiscuous miss", 30, 0, 0, 1, 0, 0, 1, -1, 1518);
        run_frame("R5 promiscuous hit", 30, 0, 0, 1, 1, 0, 1, -1, 1518);
        run_frame("R5 miss without promiscuous", 30, 0, 0, 0, 0, 0, 1, -1, 1518);
    endtask
    task automatic t_lenviol();
        run_frame("R6 over maximum", 120, 0, 0, 0, 1, 0, 1, -1, 100);
        run_frame("R6 at maximum", 100, 0, 0, 0, 1, 0, 1, -1, 100);
    endtask
    task automatic t_crc();
        run_frame("R9 CRC error", 70, 0, 0, 0, 1, 0, 0, -1, 1518);
        run_frame("R8 non-octet with bad CRC", 70, 0, 0, 0, 1, 3, 0, -1, 1518);
        run_frame("R8 non-octet with good CRC", 70, 0, 0, 0, 1, 3, 1, -1, 1518);
    endtask
    task automatic t_overrun();
        run_frame("R10 overrun clears flags", 200, 1, 0, 1, 0, 0, 0, 40, 100);
        run_frame("R10 flags return after overrun frame", 20, 0, 0, 0, 1, 0, 0, -1, 1518);
    endtask
    task automatic t_trunc();     run_frame("R7 truncated frame", 2040, 0, 0, 0, 1, 0, 1, -1, 1518); endtask

    initial begin
        t_reset();
        t_unicast();
        t_bcast();
        t_mcast_exact();
        t_short_ff();
        t_miss();
        t_lenviol();
        t_crc();
        t_overrun();
        t_trunc();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule